// File: doc/BRIEF.md
# Periodic Interrupt Register-Dump Monitor

This block watches a processor under test during fault-injection runs. On a fixed cycle period it asks the target for a snapshot by raising a request line. The target answers with a burst of 32-bit register words on a parallel bus, each qualified by a valid strobe. The block captures the words into a local buffer. When the expected number of words has arrived, it raises an interrupt toward a host. The host then reads the buffer through a random-access read port and acknowledges.

Two failure counters keep a running record of the run. One counts reset events that the target reports. The other counts dumps that did not complete inside the allowed window. A target that stalls, goes silent or resets therefore leaves a trace at the ports even when no data arrives. A status pair reports the window state and how many words the current dump holds.

Top module: `dump_watch`

## Requirements
- R1: A request tick occurs every PERIOD_CYC cycles, the first one PERIOD_CYC cycles after reset. On a tick, when no dump window is open and no host interrupt is pending, `tgt_irq_o` rises and a dump window opens (`stat_open_o`=1) with a word count of 0.
- R2: `tgt_irq_o` stays high until the first word is accepted or the window times out. It falls on the clock edge that accepts that first word.
- R3: The word accepted as the k-th of a dump (k from 0) is stored at buffer index k. `host_rdata_o` returns the entry at `host_raddr_i` combinationally.
- R4: `stat_words_o` gives the number of words accepted in the current dump. It never exceeds DUMP_WORDS, and it keeps its final value after the dump completes until the next window opens.
- R5: The edge that accepts word DUMP_WORDS-1 closes the window and sets `host_irq_o`. `host_irq_o` stays set until a cycle with `host_ack_i`=1. A completion in that same cycle wins over the acknowledge.
- R6: A tick that occurs while `host_irq_o` is set is skipped. No request is raised and the buffer is left unchanged.
- R7: If a window is still open TIMEOUT_CYC cycles after it opened, it closes, the partial dump is discarded (`stat_words_o` returns to 0) and the timeout counter increments.
- R8: A word strobed while no window is open is ignored, and `stat_words_o` does not change.
- R9: `rst_count_o` increments by one for every clock cycle in which `tgt_rst_evt_i` is high.
- R10: Both counters are CW bits wide (16 by default) and saturate at all-ones. `cnt_clear_i` zeroes both on the next edge and takes priority over any increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_irq_o | output | 1 | Dump request to the processor under test |
| dump_valid_i | input | 1 | Dump word strobe |
| dump_data_i | input | DW | Dump word |
| tgt_rst_evt_i | input | 1 | Target reset event, one count per high cycle |
| host_irq_o | output | 1 | Complete dump buffered |
| host_ack_i | input | 1 | Host acknowledge, clears host_irq_o |
| host_raddr_i | input | AW | Buffer read index |
| host_rdata_o | output | DW | Buffer word at host_raddr_i |
| cnt_clear_i | input | 1 | Synchronous clear of both counters |
| rst_count_o | output | CW | Saturating target-reset counter |
| tmo_count_o | output | CW | Saturating timeout counter |
| stat_words_o | output | NW | Words in the current dump |
| stat_open_o | output | 1 | Dump window open |

## Verification
A wrong window state shows up within one cycle. A window that is stuck open makes `stat_open_o` disagree with the reference. A window that is stuck closed leaves `stat_words_o` flat while words are strobed. A word-count error either raises `host_irq_o` on the wrong edge or leaves it low after the final word. Either way the difference is visible on the edge after the slip. A misplaced buffer write is only visible on readback while `host_irq_o` is high. For that reason the bench sweeps every index of each completed dump. An error in the age counter moves the timeout edge, and `tmo_count_o` and `stat_words_o` then differ from the reference on that exact cycle.

// File: rtl/dw_pkg.sv
package dw_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_REQ  = 2'd1,
    WS_FILL = 2'd2
  } win_state_t;

  // next value of a saturating event counter; clear dominates
  function automatic logic [31:0] sat_next(input logic [31:0] cur,
                                           input logic [31:0] top,
                                           input logic        inc,
                                           input logic        clr);
    if (clr)               return 32'd0;
    if (inc && cur != top) return cur + 32'd1;
    return cur;
  endfunction

  // all-ones value for a counter of the given width
  function automatic logic [31:0] ones_of(input int unsigned w);
    if (w >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << w) - 32'd1;
  endfunction

endpackage

// File: rtl/dw_pace.sv
module dw_pace #(
  parameter int unsigned PERIOD_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD_CYC - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dw_buffer.sv
module dw_buffer #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 80,
  parameter int unsigned AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = (32'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/dw_satcnt.sv
module dw_satcnt import dw_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [31:0] TOP = ones_of(W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= W'(sat_next(32'(q), TOP, inc, clr));
  end
endmodule

// File: rtl/dw_capture.sv
module dw_capture import dw_pkg::*; #(
  parameter int unsigned DW          = 32,
  parameter int unsigned DUMP_WORDS  = 80,
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned NW          = 7,
  parameter int unsigned AW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          word_valid,
  input  logic [DW-1:0] word_data,
  input  logic          host_ack,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          tgt_irq,
  output logic          host_irq,
  output logic          win_open,
  output logic [NW-1:0] words,
  output logic          open_evt,
  output logic          done_evt,
  output logic          timeout_evt
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  win_state_t    st_q, st_d;
  logic [NW-1:0] cnt_q;
  logic [TW-1:0] age_q;
  logic          hirq_q;
  logic          accept;

  assign win_open    = (st_q != WS_IDLE);
  assign accept      = win_open && word_valid;
  assign open_evt    = tick && (st_q == WS_IDLE) && !hirq_q;
  assign done_evt    = accept && (cnt_q == NW'(DUMP_WORDS - 1));
  assign timeout_evt = win_open && !done_evt && (age_q == TW'(TIMEOUT_CYC - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WS_IDLE: if (open_evt) st_d = WS_REQ;
      WS_REQ: begin
        if (done_evt || timeout_evt) st_d = WS_IDLE;
        else if (accept)             st_d = WS_FILL;
      end
      WS_FILL: if (done_evt || timeout_evt) st_d = WS_IDLE;
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      cnt_q  <= '0;
      age_q  <= '0;
      hirq_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (open_evt || timeout_evt) cnt_q <= '0;
      else if (accept)             cnt_q <= cnt_q + 1'b1;
      if (open_evt)      age_q <= '0;
      else if (win_open) age_q <= age_q + 1'b1;
      if (done_evt)      hirq_q <= 1'b1;
      else if (host_ack) hirq_q <= 1'b0;
    end
  end

  dw_buffer #(.DW(DW), .DEPTH(DUMP_WORDS), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (accept),
    .waddr (cnt_q[AW-1:0]),
    .wdata (word_data),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign tgt_irq  = (st_q == WS_REQ);
  assign host_irq = hirq_q;
  assign words    = cnt_q;
endmodule

// File: rtl/dump_watch.sv
module dump_watch import dw_pkg::*; #(
  parameter int unsigned PERIOD_CYC  = 50_000_000,
  parameter int unsigned TIMEOUT_CYC = 25_000_000,
  parameter int unsigned DUMP_WORDS  = 80,
  parameter int unsigned DW          = 32,
  parameter int unsigned CW          = 16,
  localparam int unsigned NW = $clog2(DUMP_WORDS + 1),
  localparam int unsigned AW = (DUMP_WORDS > 1) ? $clog2(DUMP_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          tgt_irq_o,
  input  logic          dump_valid_i,
  input  logic [DW-1:0] dump_data_i,
  input  logic          tgt_rst_evt_i,
  output logic          host_irq_o,
  input  logic          host_ack_i,
  input  logic [AW-1:0] host_raddr_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          cnt_clear_i,
  output logic [CW-1:0] rst_count_o,
  output logic [CW-1:0] tmo_count_o,
  output logic [NW-1:0] stat_words_o,
  output logic          stat_open_o
);
  // named internal events, also observed by the bound checker
  logic tick;
  logic open_evt;
  logic done_evt;
  logic timeout_evt;

  dw_pace #(.PERIOD_CYC(PERIOD_CYC)) u_pace (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  dw_capture #(
    .DW(DW), .DUMP_WORDS(DUMP_WORDS), .TIMEOUT_CYC(TIMEOUT_CYC), .NW(NW), .AW(AW)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .word_valid  (dump_valid_i),
    .word_data   (dump_data_i),
    .host_ack    (host_ack_i),
    .raddr       (host_raddr_i),
    .rdata       (host_rdata_o),
    .tgt_irq     (tgt_irq_o),
    .host_irq    (host_irq_o),
    .win_open    (stat_open_o),
    .words       (stat_words_o),
    .open_evt    (open_evt),
    .done_evt    (done_evt),
    .timeout_evt (timeout_evt)
  );

  // index 0: target resets, index 1: timeouts
  logic [1:0]    evt_inc;
  logic [CW-1:0] cnt_v [2];

  assign evt_inc = {timeout_evt, tgt_rst_evt_i};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    dw_satcnt #(.W(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (evt_inc[g]),
      .clr   (cnt_clear_i),
      .q     (cnt_v[g])
    );
  end

  assign rst_count_o = cnt_v[0];
  assign tmo_count_o = cnt_v[1];
endmodule

// File: rtl/dump_watch_chk.sv
module dump_watch_chk #(
  parameter int unsigned DUMP_WORDS = 80,
  parameter int unsigned CW         = 16,
  parameter int unsigned NW         = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tgt_irq,
  input logic          dump_valid,
  input logic          host_irq,
  input logic          host_ack,
  input logic          cnt_clear,
  input logic          tgt_rst_evt,
  input logic [CW-1:0] rst_count,
  input logic [CW-1:0] tmo_count,
  input logic [NW-1:0] words,
  input logic          win_open,
  input logic          done_evt,
  input logic          timeout_evt
);
  localparam logic [CW-1:0] MAXV = '1;

  a_r2_irq_drops_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_irq && dump_valid |=> !tgt_irq);

  a_r2_irq_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_irq |-> win_open);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    words <= NW'(DUMP_WORDS));

  a_r5_done_raises_host: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> host_irq && !win_open);

  a_r5_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq && !host_ack |=> host_irq);

  a_r6_no_request_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_irq) |-> !$past(host_irq));

  a_r7_timeout_discards: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !win_open && words == '0);

  a_r8_closed_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(words) || win_open);

  a_r9_reset_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst_evt && !cnt_clear && rst_count != MAXV |=> rst_count == CW'($past(rst_count) + 1'b1));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_count == MAXV && !cnt_clear |=> tmo_count == MAXV);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> rst_count == '0 && tmo_count == '0);
endmodule

bind dump_watch dump_watch_chk #(.DUMP_WORDS(DUMP_WORDS), .CW(CW), .NW(NW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tgt_irq     (tgt_irq_o),
  .dump_valid  (dump_valid_i),
  .host_irq    (host_irq_o),
  .host_ack    (host_ack_i),
  .cnt_clear   (cnt_clear_i),
  .tgt_rst_evt (tgt_rst_evt_i),
  .rst_count   (rst_count_o),
  .tmo_count   (tmo_count_o),
  .words       (stat_words_o),
  .win_open    (stat_open_o),
  .done_evt    (done_evt),
  .timeout_evt (timeout_evt)
);

// File: tb/dump_watch_tb.sv
module dump_watch_tb;
  localparam int PER = 200;
  localparam int TMO = 150;
  localparam int NWD = 80;
  localparam int CW  = 16;
  localparam int MAXC = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dump_valid = 1'b0;
  logic [31:0] dump_data = '0;
  logic        rst_evt = 1'b0;
  logic        host_ack = 1'b0;
  logic [6:0]  raddr = '0;
  logic        cnt_clear = 1'b0;
  logic        tgt_irq, host_irq, stat_open;
  logic [31:0] rdata;
  logic [15:0] rst_count, tmo_count;
  logic [6:0]  stat_words;

  always #10 clk = ~clk;

  dump_watch #(.PERIOD_CYC(PER), .TIMEOUT_CYC(TMO), .DUMP_WORDS(NWD), .DW(32), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tgt_irq_o(tgt_irq), .dump_valid_i(dump_valid),
    .dump_data_i(dump_data), .tgt_rst_evt_i(rst_evt), .host_irq_o(host_irq),
    .host_ack_i(host_ack), .host_raddr_i(raddr), .host_rdata_o(rdata),
    .cnt_clear_i(cnt_clear), .rst_count_o(rst_count), .tmo_count_o(tmo_count),
    .stat_words_o(stat_words), .stat_open_o(stat_open)
  );

  // behavioural reference: 0 idle, 1 requesting, 2 filling
  int          m_phase, m_pc, m_age, m_rst, m_tmo;
  bit          m_hirq;
  logic [31:0] m_q[$];
  logic [31:0] m_img[NWD];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pc = 0; m_age = 0; m_rst = 0; m_tmo = 0; m_hirq = 0;
      m_q.delete();
    end else begin
      bit tk, start, fin, lapse, took;
      tk    = (m_pc == PER - 1);
      m_pc  = tk ? 0 : m_pc + 1;
      start = tk && m_phase == 0 && !m_hirq;
      took  = (m_phase != 0) && dump_valid;
      fin = 0; lapse = 0;
      if (took) begin
        m_q.push_back(dump_data);
        if (m_q.size() == NWD) fin = 1;
      end
      if (m_phase != 0 && !fin && m_age == TMO - 1) lapse = 1;
      if (fin) begin
        foreach (m_q[i]) m_img[i] = m_q[i];
        m_phase = 0;
      end else if (lapse) begin
        m_q.delete();
        m_phase = 0;
      end else if (took) m_phase = 2;
      if (m_phase != 0 || fin || lapse) m_age++;
      if (start) begin m_phase = 1; m_age = 0; m_q.delete(); end
      if (fin) m_hirq = 1; else if (host_ack) m_hirq = 0;
      if (cnt_clear) begin m_rst = 0; m_tmo = 0; end
      else begin
        if (rst_evt && m_rst < MAXC) m_rst++;
        if (lapse && m_tmo < MAXC) m_tmo++;
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic cmp(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // one clock: sample at the falling edge, compare everything against the model
  task automatic step();
    @(negedge clk);
    cmp("R1 tgt_irq", tgt_irq, m_phase == 1);
    cmp("R4 stat_open", stat_open, m_phase != 0);
    cmp("R4 stat_words", stat_words, m_q.size());
    cmp("R5 host_irq", host_irq, m_hirq);
    cmp("R9 rst_count", rst_count, m_rst);
    cmp("R7 tmo_count", tmo_count, m_tmo);
    if (m_hirq) cmp("R3 rdata", rdata, m_img[raddr]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_req();
    while (!tgt_irq && !finished) step();
  endtask

  task automatic send(input int n, input int seed, input bit gaps);
    for (int i = 0; i < n; i++) begin
      dump_valid = 1'b1;
      dump_data  = 32'(seed * 32'h0101_0043 + i * 32'h9E37_79B9);
      step();
      dump_valid = 1'b0;
      if (gaps && (i % 7 == 3)) step();
    end
  endtask

  task automatic sweep();
    for (int i = 0; i < NWD; i++) begin
      raddr = 7'(i);
      step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset tgt_irq", tgt_irq, 0);
    cmp("R5 reset host_irq", host_irq, 0);
    cmp("R10 reset counters", {rst_count, tmo_count}, 0);
    rst_n = 1'b1;

    // R8: words before any request are dropped
    send(10, 1, 0);
    cmp("R8 stray before request", stat_words, 0);

    // R1/R2: first request, answered with gaps
    wait_req();
    cmp("R1 request up", tgt_irq, 1);
    idle(3);
    cmp("R2 request held", tgt_irq, 1);
    send(1, 2, 0);
    cmp("R2 request dropped", tgt_irq, 0);
    send(NWD - 1, 3, 1);
    cmp("R5 host interrupt", host_irq, 1);
    cmp("R4 final count", stat_words, NWD);
    sweep();

    // R6: ticks while pending are skipped
    idle(PER + 20);
    cmp("R6 no request while pending", tgt_irq, 0);
    sweep();
    host_ack = 1'b1; step(); host_ack = 1'b0;
    cmp("R5 ack clears", host_irq, 0);

    // R7: partial dump then silence
    wait_req();
    send(30, 4, 0);
    cmp("R4 partial count", stat_words, 30);
    while (stat_open && !finished) step();
    cmp("R7 timeout counted", tmo_count, 1);
    cmp("R7 partial discarded", stat_words, 0);
    send(5, 5, 0);
    cmp("R8 stray after timeout", stat_words, 0);

    // R7: no answer at all
    wait_req();
    idle(TMO + 2);
    cmp("R7 second timeout", tmo_count, 2);

    // second full dump, no gaps, fresh contents
    wait_req();
    send(NWD, 6, 0);
    sweep();
    host_ack = 1'b1; step(); host_ack = 1'b0;

    // R9 and R10
    rst_evt = 1'b1; idle(5); rst_evt = 1'b0; step();
    cmp("R9 five events", rst_count, 5);
    rst_evt = 1'b1; cnt_clear = 1'b1; step(); cnt_clear = 1'b0; rst_evt = 1'b0; step();
    cmp("R10 clear wins", rst_count, 0);
    cmp("R10 clear timeouts", tmo_count, 0);
    rst_evt = 1'b1; idle(MAXC + 6); rst_evt = 1'b0; step();
    cmp("R10 saturated", rst_count, MAXC);
    cnt_clear = 1'b1; step(); cnt_clear = 1'b0; step();
    cmp("R10 clear after saturation", rst_count, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule